// File: doc/BRIEF.md
# Endian-Selectable Data Lane Unit

This block sits between a processor's load/store stage and a 32-bit memory port. For every access it works out which byte lanes of the memory word take part, moves store data onto those lanes, and brings load data back down to bit 0 with zero extension. Byte order for data is a run-time choice. A small configuration register sets it, and software writes that register through a coprocessor-style write port. The register comes out of reset in little-endian mode.

In little-endian mode the least significant byte of a word is in bits 7:0 of the memory word. In big-endian mode it is in bits 31:24. Instruction fetches never depend on this setting: a fetch always reads the whole word, unchanged. The configuration register also holds three mode flags for address width, data width and abort timing. Those flags are stored and read back but have no effect on data movement.

The access path is purely combinational. The configuration register is the only state in the block, so a register write only affects accesses from the following cycle onward.

Top module: `endian_lane_unit`

## Requirements
- R1: After reset, `cfg_rd_data` reads 0, which means little-endian mode with all mode flags clear.
- R2: When `cfg_wr_en` is high at a clock edge, bits 7:4 of `cfg_wr_data` are stored. From the next cycle, `cfg_rd_data` returns them in bits 7:4, and every other bit reads 0. Examples: writing 0xF0 reads back 0xF0, writing 0x80 reads back 0x80, and writing 0xFFFFFFFF reads back 0xF0.
- R3: Bit 7 of the configuration register selects big-endian data mode (1) or little-endian (0). An access in the same cycle as a configuration write uses the old setting. The next cycle uses the new one.
- R4: `acc_size` encoding: 0 = byte, 1 = halfword, 2 = word, 3 = reserved. A byte access at offset n enables only lane n in little-endian mode, and only lane 3-n in big-endian mode. Lane k is `mem_be[k]` and covers bits 8k+7:8k.
- R5: A halfword access at offset 0 enables `mem_be` 4'b0011 in little-endian mode and 4'b1100 in big-endian mode. At offset 2 it enables 4'b1100 in little-endian mode and 4'b0011 in big-endian mode.
- R6: A word access at offset 0 enables all four lanes in both modes, and no bytes are swapped.
- R7: `acc_rdata` is the selected lane or lane pair of `mem_rdata`, shifted down to bit 0 and zero-extended. A word load returns `mem_rdata` unchanged.
- R8: `mem_wdata` is the low byte of `acc_wdata` repeated four times for bytes, and the low halfword repeated twice for halfwords. For word and reserved sizes it is `acc_wdata` unchanged. `mem_we` is high only for an error-free data access with `acc_write` high.
- R9: The following set `acc_err`: a halfword access at an odd offset, a word access at a nonzero offset, or the reserved size. While `acc_err` is high, `mem_be` is 0, `mem_we` is 0 and `acc_rdata` is 0.
- R10: When `acc_fetch` is high, the block ignores size, offset, direction and endianness. `mem_be` is 4'b1111, `acc_rdata` equals `mem_rdata`, and `acc_err` and `mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_wr_data | input | 32 | Configuration register write value |
| cfg_rd_data | output | 32 | Current configuration register value |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_write | input | 1 | Access is a store |
| acc_size | input | 2 | Access size code |
| acc_offset | input | 2 | Byte offset of the access within the word |
| acc_wdata | input | 32 | Store data, right-aligned |
| mem_rdata | input | 32 | Word read from memory |
| mem_be | output | 4 | Byte lane enables |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Store data placed on the lanes |
| acc_rdata | output | 32 | Aligned, zero-extended load data |
| acc_err | output | 1 | Misaligned or reserved-size access |

## Verification
A configuration write and a data access can fall in the same cycle. The bench starts a byte access at offset 0 in the same cycle that it writes bit 7, in both directions. It samples `mem_be` twice: once before the clock edge, where the old lane is expected, and once after it, where the mirrored lane is expected. All other cases come from a sweep over both byte orders, fetch and data, load and store, every size code and every offset. Expected values are computed arithmetically from the lane rules.

// File: rtl/elu_pkg.sv
package elu_pkg;

    localparam int BYTE_W  = 8;
    localparam int CFG_W   = 32;

    // Configuration bit positions; bit 7 chooses the data byte order.
    localparam int CFG_WPROG_BIT = 4;
    localparam int CFG_WDATA_BIT = 5;
    localparam int CFG_LATE_BIT  = 6;
    localparam int CFG_BIG_BIT   = 7;

    localparam logic [CFG_W-1:0] CFG_IMPL_MASK = 32'h0000_00F0;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic big_endian;
        logic late_abort;
        logic wide_data;
        logic wide_prog;
    } cfg_flags_t;

    function automatic cfg_flags_t flags_from_word(input logic [CFG_W-1:0] w);
        cfg_flags_t f;
        f.big_endian = w[CFG_BIG_BIT];
        f.late_abort = w[CFG_LATE_BIT];
        f.wide_data  = w[CFG_WDATA_BIT];
        f.wide_prog  = w[CFG_WPROG_BIT];
        return f;
    endfunction

    function automatic logic [CFG_W-1:0] word_from_flags(input cfg_flags_t f);
        logic [CFG_W-1:0] w;
        w = '0;
        w[CFG_BIG_BIT]   = f.big_endian;
        w[CFG_LATE_BIT]  = f.late_abort;
        w[CFG_WDATA_BIT] = f.wide_data;
        w[CFG_WPROG_BIT] = f.wide_prog;
        return w;
    endfunction

endpackage

// File: rtl/elu_cfg_reg.sv
module elu_cfg_reg
    import elu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] rd_data,
    output logic             big_endian
);

    cfg_flags_t flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (wr_en) begin
            flags_q <= flags_from_word(wr_data);
        end
    end

    assign rd_data    = word_from_flags(flags_q);
    assign big_endian = flags_q.big_endian;

    // R1: reset leaves the register clear
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (rd_data == '0));

    // R2: a write shows up masked on the next cycle
    p_write_next_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data == ($past(wr_data) & CFG_IMPL_MASK)));

    // R3: without a write the byte order holds
    p_hold_order_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(big_endian));

endmodule

// File: rtl/elu_lane_decode.sv
module elu_lane_decode
    import elu_pkg::*;
#(
    parameter int LANES = 4,
    localparam int OFS_W = $clog2(LANES)
) (
    input  logic             big_endian,
    input  logic             fetch,
    input  acc_size_e        size,
    input  logic [OFS_W-1:0] offset,
    output logic [LANES-1:0] be,
    output logic [OFS_W-1:0] low_lane,
    output logic             err
);

    localparam logic [OFS_W-1:0] TOP_LANE  = OFS_W'(LANES - 1);
    localparam logic [OFS_W-1:0] PAIR_TOP  = OFS_W'(LANES - 2);
    localparam logic [LANES-1:0] ONE_LANE  = LANES'(1);
    localparam logic [LANES-1:0] TWO_LANES = LANES'(3);

    always_comb begin
        be       = '0;
        low_lane = '0;
        err      = 1'b0;
        if (fetch) begin
            be = '1;
        end else begin
            unique case (size)
                SZ_BYTE: begin
                    low_lane = big_endian ? (TOP_LANE - offset) : offset;
                    be       = ONE_LANE << low_lane;
                end
                SZ_HALF: begin
                    if (offset[0]) begin
                        err = 1'b1;
                    end else begin
                        low_lane = big_endian ? (PAIR_TOP - offset) : offset;
                        be       = TWO_LANES << low_lane;
                    end
                end
                SZ_WORD: begin
                    if (offset != '0) err = 1'b1;
                    else              be  = '1;
                end
                default: err = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/elu_store_steer.sv
module elu_store_steer
    import elu_pkg::*;
#(
    parameter int LANES = 4,
    localparam int DATA_W = LANES * BYTE_W,
    localparam int HALF_W = 2 * BYTE_W
) (
    input  acc_size_e         size,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] lane_data
);

    logic [DATA_W-1:0] rep_byte;
    logic [DATA_W-1:0] rep_half;

    for (genvar i = 0; i < LANES; i++) begin : g_byte_rep
        assign rep_byte[i*BYTE_W +: BYTE_W] = wdata[BYTE_W-1:0];
    end

    for (genvar j = 0; j < LANES/2; j++) begin : g_half_rep
        assign rep_half[j*HALF_W +: HALF_W] = wdata[HALF_W-1:0];
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: lane_data = rep_byte;
            SZ_HALF: lane_data = rep_half;
            default: lane_data = wdata;
        endcase
    end

endmodule

// File: rtl/elu_load_align.sv
module elu_load_align
    import elu_pkg::*;
#(
    parameter int LANES = 4,
    localparam int DATA_W = LANES * BYTE_W,
    localparam int OFS_W = $clog2(LANES),
    localparam int HALF_W = 2 * BYTE_W
) (
    input  logic              fetch,
    input  logic              err,
    input  acc_size_e         size,
    input  logic [OFS_W-1:0]  low_lane,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] shifted;

    assign shifted = mem_rdata >> {low_lane, 3'b000};

    always_comb begin
        if (fetch) begin
            rdata = mem_rdata;
        end else if (err) begin
            rdata = '0;
        end else begin
            unique case (size)
                SZ_BYTE: rdata = {{(DATA_W-BYTE_W){1'b0}}, shifted[BYTE_W-1:0]};
                SZ_HALF: rdata = {{(DATA_W-HALF_W){1'b0}}, shifted[HALF_W-1:0]};
                default: rdata = mem_rdata;
            endcase
        end
    end

endmodule

// File: rtl/endian_lane_unit.sv
module endian_lane_unit
    import elu_pkg::*;
#(
    parameter int LANES = 4,
    localparam int DATA_W = LANES * BYTE_W,
    localparam int OFS_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [CFG_W-1:0]  cfg_wr_data,
    output logic [CFG_W-1:0]  cfg_rd_data,
    input  logic              acc_fetch,
    input  logic              acc_write,
    input  logic [1:0]        acc_size,
    input  logic [OFS_W-1:0]  acc_offset,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [LANES-1:0]  mem_be,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_err
);

    logic             big_endian;
    acc_size_e        size_e;
    logic [OFS_W-1:0] low_lane;

    assign size_e = acc_size_e'(acc_size);

    elu_cfg_reg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cfg_wr_en),
        .wr_data    (cfg_wr_data),
        .rd_data    (cfg_rd_data),
        .big_endian (big_endian)
    );

    elu_lane_decode #(.LANES(LANES)) u_dec (
        .big_endian (big_endian),
        .fetch      (acc_fetch),
        .size       (size_e),
        .offset     (acc_offset),
        .be         (mem_be),
        .low_lane   (low_lane),
        .err        (acc_err)
    );

    elu_store_steer #(.LANES(LANES)) u_st (
        .size      (size_e),
        .wdata     (acc_wdata),
        .lane_data (mem_wdata)
    );

    elu_load_align #(.LANES(LANES)) u_ld (
        .fetch     (acc_fetch),
        .err       (acc_err),
        .size      (size_e),
        .low_lane  (low_lane),
        .mem_rdata (mem_rdata),
        .rdata     (acc_rdata)
    );

    assign mem_we = acc_write & ~acc_fetch & ~acc_err;

    // R10: fetches pass the whole word through
    p_fetch_pass_r10: assert property (@(posedge clk) disable iff (rst)
        acc_fetch |-> (mem_be == '1 && acc_rdata == mem_rdata && !acc_err && !mem_we));

    // R9: an erroring access touches nothing
    p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        acc_err |-> (mem_be == '0 && !mem_we && acc_rdata == '0));

    // R4: a byte access enables exactly one lane
    p_byte_one_lane_r4: assert property (@(posedge clk) disable iff (rst)
        (!acc_fetch && size_e == SZ_BYTE) |-> ($countones(mem_be) == 1));

    // R5: an aligned halfword enables exactly two lanes
    p_half_two_lanes_r5: assert property (@(posedge clk) disable iff (rst)
        (!acc_fetch && size_e == SZ_HALF && !acc_err) |-> ($countones(mem_be) == 2));

    // R7: byte loads are zero-extended
    p_byte_zext_r7: assert property (@(posedge clk) disable iff (rst)
        (!acc_fetch && size_e == SZ_BYTE) |-> (acc_rdata[DATA_W-1:BYTE_W] == '0));

endmodule

// File: tb/tb_endian_lane_unit.sv
module tb_endian_lane_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr_en;
    logic [31:0] cfg_wr_data;
    logic [31:0] cfg_rd_data;
    logic        acc_fetch;
    logic        acc_write;
    logic [1:0]  acc_size;
    logic [1:0]  acc_offset;
    logic [31:0] acc_wdata;
    logic [31:0] mem_rdata;
    logic [3:0]  mem_be;
    logic        mem_we;
    logic [31:0] mem_wdata;
    logic [31:0] acc_rdata;
    logic        acc_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    endian_lane_unit dut (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .acc_fetch(acc_fetch), .acc_write(acc_write), .acc_size(acc_size),
        .acc_offset(acc_offset), .acc_wdata(acc_wdata), .mem_rdata(mem_rdata),
        .mem_be(mem_be), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .acc_rdata(acc_rdata), .acc_err(acc_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] v);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        rst = 1'b1; cfg_wr_en = 1'b0; cfg_wr_data = '0;
        acc_fetch = 1'b0; acc_write = 1'b0; acc_size = 2'd0; acc_offset = 2'd1;
        acc_wdata = 32'h1234_5678; mem_rdata = 32'hA1B2_C3D4;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1 cfg after reset", cfg_rd_data, 32'h0);
        check("R1 little-endian byte lane", {28'h0, mem_be}, 32'h2);

        // R2: masking and readback
        cfg_write(32'hFFFF_FFFF); #1;
        check("R2 all-ones write", cfg_rd_data, 32'hF0);
        cfg_write(32'h0000_00F0); #1;
        check("R2 0xF0 write", cfg_rd_data, 32'hF0);
        cfg_write(32'h0000_0080); #1;
        check("R2 0x80 write", cfg_rd_data, 32'h80);
        cfg_write(32'h0000_000F); #1;
        check("R2 low nibble ignored", cfg_rd_data, 32'h0);

        // R3: write and access in the same cycle, both directions
        for (int dir = 0; dir < 2; dir++) begin
            @(negedge clk);
            acc_fetch = 1'b0; acc_write = 1'b0; acc_size = 2'd0; acc_offset = 2'd0;
            cfg_wr_en = 1'b1; cfg_wr_data = (dir == 0) ? 32'h80 : 32'h00;
            #1;
            check("R3 same-cycle uses old order", {28'h0, mem_be}, (dir == 0) ? 32'h1 : 32'h8);
            @(posedge clk); #1;
            check("R3 next cycle uses new order", {28'h0, mem_be}, (dir == 0) ? 32'h8 : 32'h1);
            @(negedge clk);
            cfg_wr_en = 1'b0;
        end

        // R4..R10: full sweep
        for (int big = 0; big < 2; big++) begin
            cfg_write(big ? 32'h80 : 32'h00);
            for (int k = 0; k < 64; k++) begin
                logic        f, w, e_err, e_we;
                logic [1:0]  sz, of;
                logic [3:0]  e_be;
                logic [31:0] rd, wd, e_rd, e_wd;
                int lane;
                f  = k[5]; w = k[4]; sz = k[3:2]; of = k[1:0];
                rd = 32'h9E37_79B9 * (k + 1 + big * 64);
                wd = 32'h7F4A_7C15 ^ (k * 32'h0101_0101);
                e_err = 1'b0; e_be = 4'h0; e_rd = 32'h0;
                if (f) begin
                    e_be = 4'hF; e_rd = rd;
                end else if (sz == 2'd0) begin
                    lane = big ? 3 - of : of;
                    e_be = 4'h1 << lane;
                    e_rd = (rd >> (8 * lane)) & 32'hFF;
                end else if (sz == 2'd1) begin
                    if (of[0]) e_err = 1'b1;
                    else begin
                        lane = big ? 2 - of : of;
                        e_be = 4'h3 << lane;
                        e_rd = (rd >> (8 * lane)) & 32'hFFFF;
                    end
                end else if (sz == 2'd2) begin
                    if (of != 0) e_err = 1'b1;
                    else begin e_be = 4'hF; e_rd = rd; end
                end else begin
                    e_err = 1'b1;
                end
                e_we = w & !f & !e_err;
                e_wd = (sz == 2'd0) ? {4{wd[7:0]}} : (sz == 2'd1) ? {2{wd[15:0]}} : wd;
                @(negedge clk);
                acc_fetch = f; acc_write = w; acc_size = sz; acc_offset = of;
                acc_wdata = wd; mem_rdata = rd;
                #1;
                if (f) begin
                    check("R10 fetch enables", {28'h0, mem_be}, {28'h0, e_be});
                    check("R10 fetch data", acc_rdata, e_rd);
                    check("R10 fetch no err/we", {30'h0, acc_err, mem_we}, 32'h0);
                end else begin
                    if (sz == 2'd0) check("R4 byte lane", {28'h0, mem_be}, {28'h0, e_be});
                    else if (sz == 2'd1) check("R5 half lanes", {28'h0, mem_be}, {28'h0, e_be});
                    else check("R6 word lanes", {28'h0, mem_be}, {28'h0, e_be});
                    check("R7 load data", acc_rdata, e_rd);
                    check("R9 error flag", {31'h0, acc_err}, {31'h0, e_err});
                    check("R8 write strobe", {31'h0, mem_we}, {31'h0, e_we});
                end
                check("R8 store lanes", mem_wdata, e_wd);
            end
        end

        done = 1'b1;
        summary();
    end

endmodule